// File: doc/BRIEF.md
# Processor Control and Interrupt Level Register Block

This block is a small memory-mapped register file that sits on a simple word-wide bus with per-byte lane enables. Firmware uses it to stop the system with an exit code, to find out which processor issued an access, to read how many processors are present, and to set the level of any one of a bank of interrupt lines.

A single two-byte store to the interrupt register carries two things. Lane 0 holds the number of the target line and lane 1 holds the level. The selected line then keeps that level until a later store targets it. Only the low six address bits are decoded, so the register window repeats every 64 bytes of address space. Read data is registered: it appears on the cycle after the read request and is zero on every other cycle.

Top module: `glue_ctrl_regs`

## Requirements
- R1: Only address bits [5:0] are decoded. An access at any address behaves exactly like the same access at that address modulo 64.
- R2: A write to offset 0 with lane 0 enabled raises `halt_pulse` for exactly the next cycle and loads `wdata[7:0]` into `exit_status`. A write to offset 0 without lane 0 does neither.
- R3: A read of offset 4 returns the requester index `req_id` in bits [7:0], with all upper bits zero.
- R4: A write to offset 8 with lanes 0 and 1 both enabled uses `wdata[7:0]` as the line number. It sets that line of `irq_lines` to 1 if `wdata[15:8]` is nonzero and to 0 otherwise.
- R5: A write to offset 8 with lane 0 enabled and lane 1 disabled drives the selected line to 0. A write to offset 8 without lane 0 changes no line.
- R6: Each interrupt line holds its value until a write selects that line. One write changes at most one line.
- R7: A line number equal to or above `NUM_LINES` is ignored, and every line keeps its value.
- R8: A read of offset 12 returns `CPU_COUNT` in bits [7:0], or 1 when `CPU_COUNT` is 0.
- R9: A read of any other offset (0, 8 and the undefined words) returns all zeros.
- R10: Synchronous reset clears `irq_lines`, `halt_pulse`, `exit_status` and `rdata`.
- R11: Read data appears on `rdata` in the cycle after the read request, and `rdata` is zero in every cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_be | input | 4 | Byte lane enables, lane 0 = bits [7:0] |
| bus_wdata | input | 32 | Write data |
| req_id | input | 8 | Index of the requesting processor |
| rdata | output | 32 | Registered read data |
| halt_pulse | output | 1 | One-cycle halt request |
| exit_status | output | 8 | Last written exit code |
| irq_lines | output | NUM_LINES | Held interrupt levels |

## Verification
The bench builds the block with `NUM_LINES` = 4 and `ADDR_W` = 8. With these values, line numbers 4 to 7 test the out-of-range rule, and four 64-byte aliases cover the whole address space. A second instance uses `CPU_COUNT` = 3, so both the configured count and the default count of 1 are read back. With four lines, the bench sweeps every line number from 0 to 7 against several levels and lane-enable combinations. After each store it compares the whole output vector with a model that it computes itself.

// File: rtl/glue_pkg.sv
package glue_pkg;
  localparam int WIN_W  = 6;
  localparam int DATA_W = 32;
  localparam int BYTE_W = 8;

  localparam logic [3:0] WRD_HALT  = 4'd0;
  localparam logic [3:0] WRD_CPUID = 4'd1;
  localparam logic [3:0] WRD_IRQ   = 4'd2;
  localparam logic [3:0] WRD_NCPU  = 4'd3;

  typedef struct packed {
    logic halt_wr;
    logic irq_wr;
    logic rd_any;
    logic rd_cpuid;
    logic rd_ncpu;
  } dec_t;

  function automatic logic [3:0] word_of(input logic [WIN_W-1:0] ofs);
    return ofs[WIN_W-1:2];
  endfunction

  function automatic logic level_of(input logic [BYTE_W-1:0] lvl, input logic lane_on);
    return lane_on && (lvl != '0);
  endfunction

  function automatic logic [BYTE_W-1:0] count_of(input int unsigned cfg);
    logic [BYTE_W-1:0] v;
    v = BYTE_W'(cfg);
    return (cfg == 0) ? BYTE_W'(1) : v;
  endfunction
endpackage

// File: rtl/glue_decode.sv
module glue_decode
  import glue_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              lane0,
  output dec_t              dec
);
  logic [WIN_W-1:0] ofs;
  logic [3:0]       wrd;
  logic             wr_req, rd_req;

  assign ofs    = bus_addr[WIN_W-1:0];
  assign wrd    = word_of(ofs);
  assign wr_req = bus_valid && bus_write;
  assign rd_req = bus_valid && !bus_write;

  always_comb begin
    dec          = '0;
    dec.rd_any   = rd_req;
    dec.halt_wr  = wr_req && lane0 && (wrd == WRD_HALT);
    dec.irq_wr   = wr_req && lane0 && (wrd == WRD_IRQ);
    dec.rd_cpuid = rd_req && (wrd == WRD_CPUID);
    dec.rd_ncpu  = rd_req && (wrd == WRD_NCPU);
  end

  generate
    if (ADDR_W > WIN_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^bus_addr[ADDR_W-1:WIN_W];
    end
  endgenerate
endmodule

// File: rtl/glue_halt_reg.sv
module glue_halt_reg
  import glue_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              halt_wr,
  input  logic [BYTE_W-1:0] code,
  output logic              halt_pulse,
  output logic [BYTE_W-1:0] exit_status
);
  always_ff @(posedge clk) begin
    if (rst) begin
      halt_pulse  <= 1'b0;
      exit_status <= '0;
    end else begin
      halt_pulse <= halt_wr;
      if (halt_wr) exit_status <= code;
    end
  end
endmodule

// File: rtl/glue_irq_bank.sv
module glue_irq_bank
  import glue_pkg::*;
#(
  parameter int NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 irq_wr,
  input  logic [BYTE_W-1:0]    port_sel,
  input  logic [BYTE_W-1:0]    lvl_byte,
  input  logic                 lvl_lane,
  output logic                 port_in_range,
  output logic [NUM_LINES-1:0] irq_lines
);
  localparam int SEL_W = BYTE_W + 1;
  logic new_level;

  assign new_level     = level_of(lvl_byte, lvl_lane);
  assign port_in_range = ({1'b0, port_sel} < SEL_W'(NUM_LINES));

  generate
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      logic hit;
      assign hit = irq_wr && ({1'b0, port_sel} == SEL_W'(i));
      always_ff @(posedge clk) begin
        if (rst)      irq_lines[i] <= 1'b0;
        else if (hit) irq_lines[i] <= new_level;
      end
    end
  endgenerate
endmodule

// File: rtl/glue_rdmux.sv
module glue_rdmux
  import glue_pkg::*;
#(
  parameter int CPU_COUNT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_any,
  input  logic              rd_cpuid,
  input  logic              rd_ncpu,
  input  logic [BYTE_W-1:0] req_id,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [BYTE_W-1:0] COUNT_VAL = count_of(CPU_COUNT);
  logic [BYTE_W-1:0] sel_byte;

  always_comb begin
    sel_byte = '0;
    if (rd_cpuid) sel_byte = req_id;
    if (rd_ncpu)  sel_byte = COUNT_VAL;
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (rd_any) rdata <= {{(DATA_W-BYTE_W){1'b0}}, sel_byte};
    else             rdata <= '0;
  end
endmodule

// File: rtl/glue_ctrl_regs.sv
module glue_ctrl_regs
  import glue_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int NUM_LINES = 8,
  parameter int CPU_COUNT = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [3:0]           bus_be,
  input  logic [31:0]          bus_wdata,
  input  logic [7:0]           req_id,
  output logic [31:0]          rdata,
  output logic                 halt_pulse,
  output logic [7:0]           exit_status,
  output logic [NUM_LINES-1:0] irq_lines
);
  dec_t dec;
  logic halt_wr_evt, irq_wr_evt, port_ok_evt;
  logic unused_bits;

  assign unused_bits = ^{bus_wdata[31:16], bus_be[3:2]};

  glue_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .lane0(bus_be[0]), .dec(dec)
  );

  assign halt_wr_evt = dec.halt_wr;
  assign irq_wr_evt  = dec.irq_wr;

  glue_halt_reg u_halt (
    .clk(clk), .rst(rst), .halt_wr(halt_wr_evt), .code(bus_wdata[7:0]),
    .halt_pulse(halt_pulse), .exit_status(exit_status)
  );

  glue_irq_bank #(.NUM_LINES(NUM_LINES)) u_irq (
    .clk(clk), .rst(rst), .irq_wr(irq_wr_evt), .port_sel(bus_wdata[7:0]),
    .lvl_byte(bus_wdata[15:8]), .lvl_lane(bus_be[1]),
    .port_in_range(port_ok_evt), .irq_lines(irq_lines)
  );

  glue_rdmux #(.CPU_COUNT(CPU_COUNT)) u_rd (
    .clk(clk), .rst(rst), .rd_any(dec.rd_any), .rd_cpuid(dec.rd_cpuid),
    .rd_ncpu(dec.rd_ncpu), .req_id(req_id), .rdata(rdata)
  );
endmodule

// File: rtl/glue_ctrl_regs_chk.sv
module glue_ctrl_regs_chk #(
  parameter int ADDR_W    = 16,
  parameter int NUM_LINES = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_valid,
  input logic                 bus_write,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [3:0]           bus_be,
  input logic [31:0]          bus_wdata,
  input logic [31:0]          rdata,
  input logic                 halt_pulse,
  input logic [7:0]           exit_status,
  input logic [NUM_LINES-1:0] irq_lines,
  input logic                 irq_wr_evt,
  input logic                 port_ok_evt
);
  logic halt_req, oor_req, rd_req;
  assign halt_req = bus_valid && bus_write && bus_be[0] && (bus_addr[5:2] == 4'd0);
  assign oor_req  = irq_wr_evt && ({1'b0, bus_wdata[7:0]} >= 9'(NUM_LINES));
  assign rd_req   = bus_valid && !bus_write;

  AST_HALT_CAUSE: assert property (@(posedge clk) disable iff (rst)
    halt_pulse |-> $past(halt_req)); // R2
  AST_HALT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    halt_req |=> halt_pulse); // R2
  AST_EXIT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    halt_pulse |-> exit_status == $past(bus_wdata[7:0])); // R2
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(irq_wr_evt) |-> $stable(irq_lines)); // R6
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    $countones(irq_lines ^ $past(irq_lines)) <= 1); // R6
  AST_IRQ_OOR: assert property (@(posedge clk) disable iff (rst)
    $past(oor_req) |-> $stable(irq_lines)); // R7
  AST_OOR_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq_wr_evt && port_ok_evt |-> !oor_req); // R7
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_req) |-> rdata == 32'd0); // R11
endmodule

bind glue_ctrl_regs glue_ctrl_regs_chk #(.ADDR_W(ADDR_W), .NUM_LINES(NUM_LINES)) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata), .rdata(rdata),
  .halt_pulse(halt_pulse), .exit_status(exit_status), .irq_lines(irq_lines),
  .irq_wr_evt(irq_wr_evt), .port_ok_evt(port_ok_evt)
);

// File: tb/tb_glue_ctrl_regs.sv
module tb_glue_ctrl_regs;
  localparam int AW = 8;
  localparam int NL = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [3:0] bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [7:0] req_id = '0;
  logic [31:0] rdata, rdata2;
  logic halt_pulse, halt2;
  logic [7:0] exit_status, exit2;
  logic [NL-1:0] irq_lines, irq2;
  int errors = 0, checks = 0;
  logic [NL-1:0] exp_lines = '0;

  always #2.5 clk = ~clk;

  glue_ctrl_regs #(.ADDR_W(AW), .NUM_LINES(NL), .CPU_COUNT(0)) dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata), .req_id(req_id),
    .rdata(rdata), .halt_pulse(halt_pulse), .exit_status(exit_status), .irq_lines(irq_lines));

  glue_ctrl_regs #(.ADDR_W(AW), .NUM_LINES(NL), .CPU_COUNT(3)) dut2 (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata), .req_id(req_id),
    .rdata(rdata2), .halt_pulse(halt2), .exit_status(exit2), .irq_lines(irq2));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d, output logic [31:0] d2);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_be = 4'hF;
    @(negedge clk);
    bus_valid = 1'b0; bus_be = '0;
    d = rdata; d2 = rdata2;
  endtask

  initial begin
    #1ms;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d, d2;
    logic [31:0] lvls [4];
    logic [3:0]  bes  [4];
    lvls = '{32'h1, 32'h0, 32'h80, 32'h0};
    bes  = '{4'b0011, 4'b0001, 4'b1111, 4'b0010};
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 irq", 32'(irq_lines), 0);
    check("R10 halt", 32'(halt_pulse), 0);
    check("R10 status", 32'(exit_status), 0);
    check("R10 rdata", rdata, 0);
    rst = 1'b0;

    // R1 R3 R8 R9 R11: read sweep across all words and four aliases
    for (int al = 0; al < 4; al++) begin
      for (int w = 0; w < 16; w++) begin
        req_id = 8'(al * 16 + w + 5);
        rd(AW'(al * 64 + w * 4), d, d2);
        if (w == 1)      check("R3 R1 cpu index", d, 32'(req_id));
        else if (w == 3) begin
          check("R8 R1 default count", d, 32'd1);
          check("R8 configured count", d2, 32'd3);
        end else         check("R9 R1 zero read", d, 0);
        @(negedge clk);
        check("R11 idle rdata", rdata, 0);
      end
    end

    // R4 R5 R6 R7 R1: interrupt sweep
    for (int p = 0; p < 8; p++) begin
      for (int k = 0; k < 4; k++) begin
        wr(AW'(8 + 64 * (p % 4)), bes[k], {16'h0, lvls[k][7:0], 8'(p)});
        if (bes[k][0] && p < NL) exp_lines[p] = bes[k][1] && (lvls[k][7:0] != 0);
        check(p >= NL ? "R7 out-of-range port" : (bes[k][1] ? "R4 level write" : "R5 single lane"),
              32'(irq_lines), 32'(exp_lines));
      end
      if (p < NL) begin
        wr(AW'(8), 4'b0011, {16'h0, 8'h1, 8'(p)});
        exp_lines[p] = 1'b1;
        check("R4 R6 set and hold", 32'(irq_lines), 32'(exp_lines));
      end
    end
    repeat (4) @(negedge clk);
    check("R6 held levels", 32'(irq_lines), 32'(exp_lines));

    // R2 halt sweep
    for (int v = 0; v < 256; v += 17) begin
      wr(AW'(64 * (v % 4)), 4'b0001, 32'(v) | 32'hABCD_0000);
      check("R2 halt pulse", 32'(halt_pulse), 1);
      check("R2 exit status", 32'(exit_status), 32'(v));
      @(negedge clk);
      check("R2 pulse width", 32'(halt_pulse), 0);
    end
    wr(AW'(0), 4'b1110, 32'h0000_0077);
    check("R2 no lane0 no halt", 32'(halt_pulse), 0);
    check("R2 no lane0 status kept", 32'(exit_status), 32'd255);

    // R10 reset clears held lines
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R10 irq after reset", 32'(irq_lines), 0);
    check("R10 status after reset", 32'(exit_status), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule